// File: doc/BRIEF.md
# Fused Two-Operation Execute Lane

This block is the execute stage of one issue lane that handles a fused pair of dependent single-cycle operations. The first operation (the head) runs in an ordinary two-input ALU. Alongside it, a collapsed three-input unit works out the second operation (the tail) straight from the original operands. The tail therefore never waits for the head result. No result is routed back through a register file or a forwarding path.

Each cycle the lane accepts two opcodes, two register source values, an immediate and a few selection bits. One clock edge later it presents both results, a write enable for each destination and a taken flag. The taken flag is used when the tail is a conditional branch on the head value, and the branch then resolves in the same cycle as its test. A pair made of two add/subtract operations goes through a carry-save compressor feeding one adder. Any other pair uses a local copy of the head function in front of the tail function.

Top module: `macroOpAluLane`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, outValid, headWe, tailWe and branchTaken are 0 and both results are 0.
- R2: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge (one cycle of latency).
- R3: The head result is srcA OP x. OP is chosen by headOp: 0 add, 1 subtract (srcA minus x), 2 and, 3 or, 4 xor. x is srcB when headImmSel is 0 and imm when headImmSel is 1.
- R4: When hasTail is 1 and tailOp is 0 to 4, the tail result is H OP y. H is the head value, OP uses the same encoding as headOp, and subtract means H minus y. y is chosen by tailSel: 0 srcA, 1 srcB, 2 imm, 3 zero.
- R5: When hasTail is 0, tailResult is 0, tailWe is 0 and branchTaken is 0.
- R6: headWe equals inValid and headWrReq and (headOp at most 4). tailWe equals inValid and tailWrReq and hasTail and (tailOp at most 4).
- R7: tailOp 5 is a branch taken when H is zero, and tailOp 6 is a branch taken when H is nonzero. A branch tail has tailWe 0 and tailResult 0. tailOp 7 gives no write, no taken and a result of 0.
- R8: headOp values 5 to 7 are reserved. They give a head result of 0 and headWe 0, and the tail uses 0 as H.
- R9: When inValid is 0, the next outputs are all 0.
- R10: All arithmetic wraps modulo 2^W, including a subtract in both head and tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A fused pair is present this cycle |
| headOp | input | 3 | Head opcode |
| tailOp | input | 3 | Tail opcode |
| hasTail | input | 1 | A tail operation is present |
| tailSel | input | 2 | Tail second-operand select |
| headImmSel | input | 1 | Head second operand is the immediate |
| headWrReq | input | 1 | Head writes its destination |
| tailWrReq | input | 1 | Tail writes its destination |
| srcA | input | W | First register source value |
| srcB | input | W | Second register source value |
| imm | input | W | Immediate value |
| outValid | output | 1 | Registered result is valid |
| headResult | output | W | Head result |
| headWe | output | 1 | Head destination write enable |
| tailResult | output | W | Tail result |
| tailWe | output | 1 | Tail destination write enable |
| branchTaken | output | 1 | Fused branch resolved as taken |

## Verification
The bench runs every pairing of head and tail opcodes, reserved codes included, and compares each result against a two-step sequential reference. A design that mixed up the carry-in of a subtract, or took the tail operand from the wrong source, would show it in those pairings. Directed cases cover wraparound through the largest value with subtracts on both sides, as well as a branch on a zero and on a nonzero head value. A design whose fused path lost a carry would get the wraparound wrong, and one that resolved the branch on the wrong value would set the taken flag wrongly. Further cases cover a missing tail, invalid cycles and reserved opcodes, where a design that leaked a stale value or raised a write enable would be caught at the ports.

// File: rtl/laneAluPkg.sv
package laneAluPkg;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;
  localparam logic [2:0] OP_BRZ = 3'd5;
  localparam logic [2:0] OP_BRNZ = 3'd6;

  localparam logic [1:0] SEL_SRCA = 2'd0;
  localparam logic [1:0] SEL_SRCB = 2'd1;
  localparam logic [1:0] SEL_IMM  = 2'd2;
  localparam logic [1:0] SEL_ZERO = 2'd3;

  typedef struct packed {
    logic       valid;
    logic       headLegal;
    logic [2:0] headFn;
    logic       headUseImm;
    logic       tailAlu;
    logic       tailBranch;
    logic       brOnZero;
    logic [2:0] tailFn;
    logic [1:0] otherSel;
    logic       arithPair;
    logic       headSub;
    logic       tailSub;
    logic       headWe;
    logic       tailWe;
  } laneStrobes_t;

endpackage

// File: rtl/laneCtrl.sv
module laneCtrl
  import laneAluPkg::*;
(
  input  logic         inValid,
  input  logic [2:0]   headOp,
  input  logic [2:0]   tailOp,
  input  logic         hasTail,
  input  logic [1:0]   tailSel,
  input  logic         headImmSel,
  input  logic         headWrReq,
  input  logic         tailWrReq,
  output laneStrobes_t strb
);

  logic headIsArith;
  logic tailIsArith;

  always_comb begin
    headIsArith = (headOp == OP_ADD) || (headOp == OP_SUB);
    tailIsArith = (tailOp == OP_ADD) || (tailOp == OP_SUB);

    strb            = '0;
    strb.valid      = inValid;
    strb.headLegal  = (headOp <= OP_XOR);
    strb.headFn     = headOp;
    strb.headUseImm = headImmSel;
    strb.tailAlu    = hasTail && (tailOp <= OP_XOR);
    strb.tailBranch = hasTail && ((tailOp == OP_BRZ) || (tailOp == OP_BRNZ));
    strb.brOnZero   = (tailOp == OP_BRZ);
    strb.tailFn     = tailOp;
    strb.otherSel   = tailSel;
    strb.arithPair  = headIsArith && hasTail && tailIsArith;
    strb.headSub    = (headOp == OP_SUB);
    strb.tailSub    = (tailOp == OP_SUB);
    strb.headWe     = inValid && headWrReq && (headOp <= OP_XOR);
    strb.tailWe     = inValid && tailWrReq && hasTail && (tailOp <= OP_XOR);
  end

endmodule

// File: rtl/laneDatapath.sv
module laneDatapath
  import laneAluPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  laneStrobes_t strb,
  input  logic [W-1:0] srcA,
  input  logic [W-1:0] srcB,
  input  logic [W-1:0] imm,
  output logic         outValid,
  output logic [W-1:0] headResult,
  output logic         headWe,
  output logic [W-1:0] tailResult,
  output logic         tailWe,
  output logic         branchTaken
);

  localparam logic [W-1:0] ZERO_W = '0;

  function automatic logic [W-1:0] aluFn(input logic [2:0] fn,
                                         input logic [W-1:0] x,
                                         input logic [W-1:0] y);
    case (fn)
      OP_ADD:  return x + y;
      OP_SUB:  return x - y;
      OP_AND:  return x & y;
      OP_OR:   return x | y;
      OP_XOR:  return x ^ y;
      default: return ZERO_W;
    endcase
  endfunction

  // Head: plain two-input ALU
  logic [W-1:0] headB;
  logic [W-1:0] headVal;

  always_comb begin
    headB   = strb.headUseImm ? imm : srcB;
    headVal = aluFn(strb.headFn, srcA, headB);
  end

  // Tail: collapsed three-input unit, fed only by the original operands
  logic [W-1:0] other;
  logic [W-1:0] csaX, csaY, csaZ, csaSum, csaMaj, carryVec;
  logic [W-1:0] fusedArith;
  logic [W-1:0] localHead;
  logic [W-1:0] tailVal;
  logic         localZero;

  always_comb begin
    case (strb.otherSel)
      SEL_SRCA: other = srcA;
      SEL_SRCB: other = srcB;
      SEL_IMM:  other = imm;
      default:  other = ZERO_W;
    endcase

    // add/sub pair: a +/- b +/- c through a 3:2 compressor and one adder
    csaX       = srcA;
    csaY       = headB ^ {W{strb.headSub}};
    csaZ       = other ^ {W{strb.tailSub}};
    csaSum     = csaX ^ csaY ^ csaZ;
    csaMaj     = (csaX & csaY) | (csaX & csaZ) | (csaY & csaZ);
    carryVec   = {csaMaj[W-2:0], strb.headSub};
    fusedArith = csaSum + carryVec + {{(W-1){1'b0}}, strb.tailSub};

    // other pairs: local head function in front of the tail function
    localHead  = strb.headLegal ? aluFn(strb.headFn, srcA, headB) : ZERO_W;
    localZero  = (localHead == ZERO_W);
    tailVal    = strb.arithPair ? fusedArith : aluFn(strb.tailFn, localHead, other);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      headResult  <= '0;
      headWe      <= 1'b0;
      tailResult  <= '0;
      tailWe      <= 1'b0;
      branchTaken <= 1'b0;
    end else begin
      outValid    <= strb.valid;
      headResult  <= (strb.valid && strb.headLegal) ? headVal : ZERO_W;
      headWe      <= strb.headWe;
      tailResult  <= (strb.valid && strb.tailAlu) ? tailVal : ZERO_W;
      tailWe      <= strb.tailWe;
      branchTaken <= strb.valid && strb.tailBranch &&
                     (strb.brOnZero ? localZero : !localZero);
    end
  end

endmodule

// File: rtl/macroOpAluLane.sv
module macroOpAluLane
  import laneAluPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [2:0]   headOp,
  input  logic [2:0]   tailOp,
  input  logic         hasTail,
  input  logic [1:0]   tailSel,
  input  logic         headImmSel,
  input  logic         headWrReq,
  input  logic         tailWrReq,
  input  logic [W-1:0] srcA,
  input  logic [W-1:0] srcB,
  input  logic [W-1:0] imm,
  output logic         outValid,
  output logic [W-1:0] headResult,
  output logic         headWe,
  output logic [W-1:0] tailResult,
  output logic         tailWe,
  output logic         branchTaken
);

  laneStrobes_t strb;

  laneCtrl uCtrl (
    .inValid   (inValid),
    .headOp    (headOp),
    .tailOp    (tailOp),
    .hasTail   (hasTail),
    .tailSel   (tailSel),
    .headImmSel(headImmSel),
    .headWrReq (headWrReq),
    .tailWrReq (tailWrReq),
    .strb      (strb)
  );

  laneDatapath #(.W(W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .srcA       (srcA),
    .srcB       (srcB),
    .imm        (imm),
    .outValid   (outValid),
    .headResult (headResult),
    .headWe     (headWe),
    .tailResult (tailResult),
    .tailWe     (tailWe),
    .branchTaken(branchTaken)
  );

endmodule

// File: rtl/macroOpAluLaneChk.sv
module macroOpAluLaneChk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [2:0]   headOp,
  input logic [2:0]   tailOp,
  input logic         hasTail,
  input logic         headWrReq,
  input logic         tailWrReq,
  input logic         outValid,
  input logic [W-1:0] headResult,
  input logic         headWe,
  input logic [W-1:0] tailResult,
  input logic         tailWe,
  input logic         branchTaken
);

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !headWe && !tailWe && !branchTaken));

  // R5
  no_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !hasTail) |=> (!tailWe && !branchTaken && tailResult == '0));

  // R7
  branch_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && hasTail && tailOp > 3'd4) |=> (!tailWe && tailResult == '0));

  // R8
  reserved_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && headOp > 3'd4) |=> (!headWe && headResult == '0));

  // R6
  head_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && headWrReq && headOp <= 3'd4) |=> headWe);

  // R6
  tail_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && tailWrReq && hasTail && tailOp <= 3'd4) |=> tailWe);

  // R7
  taken_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> !tailWe);

endmodule

bind macroOpAluLane macroOpAluLaneChk #(.W(W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .headOp     (headOp),
  .tailOp     (tailOp),
  .hasTail    (hasTail),
  .headWrReq  (headWrReq),
  .tailWrReq  (tailWrReq),
  .outValid   (outValid),
  .headResult (headResult),
  .headWe     (headWe),
  .tailResult (tailResult),
  .tailWe     (tailWe),
  .branchTaken(branchTaken)
);

// File: tb/sim_macroOpAluLane.sv
module sim_macroOpAluLane;

  localparam int W = 16;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  typedef struct packed {
    logic [2:0]   hOp;
    logic [2:0]   tOp;
    logic         hasT;
    logic [1:0]   sel;
    logic         hImm;
    logic         hReq;
    logic         tReq;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] k;
  } stim_t;

  // hOp, tOp, hasT, sel, hImm, hReq, tReq, a, b, imm
  localparam stim_t TAB [0:9] = '{
    '{3'd0, 3'd0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 16'd100,  16'd23,   16'd7},
    '{3'd1, 3'd1, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 16'd5,    16'd9,    16'd3},     // R10 wrap
    '{3'd0, 3'd1, 1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 16'hFFFF, 16'd4,    16'd1},     // R10 max+1
    '{3'd2, 3'd0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 16'hF0F0, 16'h3C3C, 16'h0101},
    '{3'd4, 3'd3, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 16'hAAAA, 16'h0000, 16'h5555},
    '{3'd1, 3'd5, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 16'd42,   16'd42,   16'd0},     // R7 zero
    '{3'd1, 3'd6, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 16'd42,   16'd41,   16'd0},     // R7 nonzero
    '{3'd3, 3'd2, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 16'h1200, 16'h0034, 16'h0000},  // R5
    '{3'd6, 3'd0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 16'd9,    16'd9,    16'd77},    // R8
    '{3'd1, 3'd0, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 16'd0,    16'd0,    16'd1}      // R10
  };

  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [2:0]   headOp, tailOp;
  logic         hasTail;
  logic [1:0]   tailSel;
  logic         headImmSel, headWrReq, tailWrReq;
  logic [W-1:0] srcA, srcB, imm;
  logic         outValid, headWe, tailWe, branchTaken;
  logic [W-1:0] headResult, tailResult;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  macroOpAluLane #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .headOp(headOp), .tailOp(tailOp),
    .hasTail(hasTail), .tailSel(tailSel), .headImmSel(headImmSel),
    .headWrReq(headWrReq), .tailWrReq(tailWrReq), .srcA(srcA), .srcB(srcB),
    .imm(imm), .outValid(outValid), .headResult(headResult), .headWe(headWe),
    .tailResult(tailResult), .tailWe(tailWe), .branchTaken(branchTaken)
  );

  function automatic logic [W-1:0] refAlu(input logic [2:0] op,
                                          input logic [W-1:0] x,
                                          input logic [W-1:0] y);
    case (op)
      3'd0: return x + y;
      3'd1: return x - y;
      3'd2: return x & y;
      3'd3: return x | y;
      3'd4: return x ^ y;
      default: return '0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input stim_t s, input logic v);
    inValid    = v;
    headOp     = s.hOp;
    tailOp     = s.tOp;
    hasTail    = s.hasT;
    tailSel    = s.sel;
    headImmSel = s.hImm;
    headWrReq  = s.hReq;
    tailWrReq  = s.tReq;
    srcA       = s.a;
    srcB       = s.b;
    imm        = s.k;
  endtask

  // Sequential two-step reference: head first, then tail on the head value
  task automatic applyAndCheck(input stim_t s);
    logic [W-1:0] hv, y, eHead, eTail;
    logic eHwe, eTwe, eTaken;
    @(negedge clk);
    drive(s, 1'b1);
    hv = refAlu(s.hOp, s.a, s.hImm ? s.k : s.b);
    case (s.sel)
      2'd0: y = s.a;
      2'd1: y = s.b;
      2'd2: y = s.k;
      default: y = '0;
    endcase
    eHead  = hv;
    eHwe   = s.hReq && (s.hOp <= 3'd4);
    eTail  = (s.hasT && s.tOp <= 3'd4) ? refAlu(s.tOp, hv, y) : '0;
    eTwe   = s.tReq && s.hasT && (s.tOp <= 3'd4);
    eTaken = s.hasT && ((s.tOp == 3'd5 && hv == '0) || (s.tOp == 3'd6 && hv != '0));
    @(negedge clk);
    check(outValid == 1'b1, "R2 outValid", W'(outValid), W'(1));
    check(headResult == eHead, "R3/R8 headResult", headResult, eHead);
    check(tailResult == eTail, "R4/R5/R10 tailResult", tailResult, eTail);
    check(headWe == eHwe && tailWe == eTwe, "R6 write enables",
          W'({headWe, tailWe}), W'({eHwe, eTwe}));
    check(branchTaken == eTaken, "R7 branchTaken", W'(branchTaken), W'(eTaken));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    stim_t s;
    rstN = 1'b0;
    drive(TAB[0], 1'b1);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!outValid && !headWe && !tailWe && !branchTaken, "R1 flags", 
          W'({outValid, headWe, tailWe, branchTaken}), '0);
    check(headResult == '0 && tailResult == '0, "R1 results", headResult | tailResult, '0);
    rstN = 1'b1;

    // table walk
    for (int i = 0; i < 10; i++) applyAndCheck(TAB[i]);

    // all opcode pairs, R3 R4 R7 R8, rotating operand selects
    for (int h = 0; h < 8; h++) begin
      for (int t = 0; t < 8; t++) begin
        s = '{3'(h), 3'(t), 1'b1, 2'(h + t), 1'((h ^ t) & 1), 1'b1, 1'b1,
              16'h8F31 + 16'(h * 911), 16'h7A0C - 16'(t * 313), 16'h00F5 + 16'(h * t)};
        applyAndCheck(s);
      end
    end

    // R10: wrap with subtract on both sides: 0 - 1 - 1 = 0xFFFE
    s = '{3'd1, 3'd1, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 16'd0, 16'd1, 16'd1};
    applyAndCheck(s);
    check(tailResult == 16'hFFFE, "R10 double subtract", tailResult, 16'hFFFE);
    // R10: max + max + max
    s = '{3'd0, 3'd0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, MAXV, MAXV, 16'd0};
    applyAndCheck(s);
    check(tailResult == 16'hFFFD, "R10 triple max", tailResult, 16'hFFFD);

    // R2: output holds until the next rising edge
    @(negedge clk);
    s = '{3'd0, 3'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 16'd1, 16'd2, 16'd0};
    drive(s, 1'b1);
    #5;
    check(headResult == MAXV + MAXV, "R2 holds before edge", headResult, MAXV + MAXV);
    @(negedge clk);
    check(headResult == 16'd3, "R2 updates after edge", headResult, 16'd3);

    // R9: invalid input clears every output
    s = '{3'd0, 3'd0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 16'd5, 16'd6, 16'd7};
    drive(s, 1'b0);
    @(negedge clk);
    check(!outValid && !headWe && !tailWe && !branchTaken, "R9 flags",
          W'({outValid, headWe, tailWe, branchTaken}), '0);
    check(headResult == '0 && tailResult == '0, "R9 results", headResult | tailResult, '0);

    // R5: no tail, tail write request ignored
    s = '{3'd0, 3'd1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 16'd5, 16'd6, 16'd7};
    drive(s, 1'b1);
    @(negedge clk);
    check(!tailWe && tailResult == '0 && headResult == 16'd11, "R5 no tail",
          tailResult, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule